// File: doc/BRIEF.md
# DDR SDRAM Closed-Page Read Sequencer

This block sits on the controller side of a four-bank DDR SDRAM and turns one accepted read request into a complete closed-page access. It opens the requested row, issues a single column read without automatic precharge, then closes the bank with an explicit precharge. The precharge can close either the one bank that was read or every bank at once, depending on a flag that travels with the request.

All four row-cycle limits are kept by independent down-counters: activate-to-read, activate-to-precharge, precharge-to-activate and activate-to-activate. A request is taken only when the sequencer is idle and the activate-to-activate and precharge-to-activate windows have both run out. A request held high while the block is busy is therefore taken on the first cycle the device allows. A read-data-valid strobe marks the two clocks, four half-clock beats, in which the device drives the burst.

The command bus is fully registered and clock enable stays high. Initialization, refresh, mode programming and data-strobe capture are handled elsewhere.

Top module: `ddr_rd_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, `ready` is 1, `cke` is 1, `rd_valid` is 0 and the command bus carries NOP.
- R2: A request is taken on a rising edge where `req` and `ready` are both 1, and only then. The next cycle carries ACTIVE with `ba` equal to the request bank and `addr` equal to the request row. A request presented while `ready` is 0 waits.
- R3: READ appears exactly RCD_EFF = max(T_RCD_CYC, 2) cycles after ACTIVE. `addr` equals the column zero-extended, so A10 (`addr[10]`) is 0 and no autoprecharge occurs, and `ba` equals the bank.
- R4: PRECHARGE appears exactly RAS_EFF = max(T_RAS_CYC, RCD_EFF + BURST_LEN/2) cycles after ACTIVE. `addr[10]` equals the request's all-bank flag. When that flag is 0, `ba` equals the request bank.
- R5: A new ACTIVE lies at least RC_EFF = max(T_RC_CYC, RAS_EFF + RP_EFF) cycles after the previous ACTIVE, and at least RP_EFF = max(T_RP_CYC, 2) cycles after the previous PRECHARGE. A request already waiting produces its ACTIVE exactly RC_EFF cycles after the previous one.
- R6: `ready` is 1 exactly when no access is in progress, at least RC_EFF-1 cycles have passed since the last ACTIVE, and at least RP_EFF-1 cycles have passed since the last PRECHARGE. While `ready` is 1, the bus carries NOP.
- R7: `rd_valid` is 1 in exactly the two cycles CAS_LAT and CAS_LAT+1 after the READ cycle, and 0 at all other times.
- R8: The bus {cs_n, ras_n, cas_n, we_n} carries only NOP=0111, ACTIVE=0011, READ=0101 and PRECHARGE=0010. A cycle after any non-NOP command always carries NOP.
- R9: `cke` is 1 in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Read request valid |
| req_bank | input | BA_W | Bank of the request |
| req_row | input | ROW_W | Row of the request |
| req_col | input | COL_W | Column of the burst start |
| req_all_pre | input | 1 | 1: close all banks after the read; 0: close only this bank |
| ready | output | 1 | Request is taken on this edge if `req` is high |
| cke | output | 1 | Clock enable to the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ROW_W | Multiplexed address bus |
| ba | output | BA_W | Bank select |
| rd_valid | output | 1 | Device drives read data in this cycle |

## Verification
The bench sends back-to-back requests to the same bank. An acceptance gate that ignored the activate-to-activate counter would place the second ACTIVE too early, and a gate that was too conservative would miss the exact RC_EFF landing. Requests with the all-bank flag set and cleared check the A10 choice at precharge; a design that confused it with the read's A10 would raise autoprecharge on the READ or close the wrong set of banks. Columns with all ones and all zeros, and random gaps of zero to fourteen cycles between requests, check the column field and the data-valid window. An off-by-one in the latency pipe shifts `rd_valid` by one cycle, and a missed command gap puts two commands on adjacent cycles.

// File: rtl/ddr_rd_pkg.sv
package ddr_rd_pkg;

  // Command code on {cs_n, ras_n, cas_n, we_n}
  typedef logic [3:0] cmd_t;
  localparam cmd_t CMD_NOP = 4'b0111;
  localparam cmd_t CMD_ACT = 4'b0011;
  localparam cmd_t CMD_RD  = 4'b0101;
  localparam cmd_t CMD_PRE = 4'b0010;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_RD  = 2'd1,
    ST_WAIT_PRE = 2'd2
  } seq_st_t;

  // Timer indices
  localparam int TM_RCD = 0;
  localparam int TM_RAS = 1;
  localparam int TM_RP  = 2;
  localparam int TM_RC  = 3;
  localparam int TM_NUM = 4;

  // Address bit that selects autoprecharge / all-bank precharge
  localparam int AP_BIT = 10;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr_rd_tmr.sv
module ddr_rd_tmr #(
  parameter int W    = 4,
  parameter int LOAD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ld,
  output logic done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (ld) begin
      cnt <= W'(LOAD);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/ddr_rd_win.sv
module ddr_rd_win #(
  parameter int CAS_LAT = 2,
  parameter int BEATS   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_go,
  output logic valid
);
  localparam int DEPTH = CAS_LAT + BEATS;

  logic [DEPTH-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= '0;
    end else begin
      pipe <= {pipe[DEPTH-2:0], rd_go};
    end
  end

  assign valid = |pipe[CAS_LAT +: BEATS];
endmodule

// File: rtl/ddr_rd_seq.sv
module ddr_rd_seq
  import ddr_rd_pkg::*;
#(
  parameter int ROW_W     = 12,
  parameter int COL_W     = 8,
  parameter int BA_W      = 2,
  parameter int T_RCD_CYC = 3,
  parameter int T_RAS_CYC = 6,
  parameter int T_RP_CYC  = 3,
  parameter int T_RC_CYC  = 9,
  parameter int CAS_LAT   = 2,
  parameter int BURST_LEN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [BA_W-1:0]  req_bank,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic             req_all_pre,
  output logic             ready,
  output logic             cke,
  output logic             cs_n,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [ROW_W-1:0] addr,
  output logic [BA_W-1:0]  ba,
  output logic             rd_valid
);
  localparam int BEATS   = BURST_LEN / 2;
  localparam int RCD_EFF = imax(T_RCD_CYC, 2);
  localparam int RAS_EFF = imax(T_RAS_CYC, RCD_EFF + BEATS);
  localparam int RP_EFF  = imax(T_RP_CYC, 2);
  localparam int RC_EFF  = imax(T_RC_CYC, RAS_EFF + RP_EFF);
  localparam int TW      = $clog2(RC_EFF + 1);

  function automatic int load_of(input int idx);
    case (idx)
      TM_RCD:  return RCD_EFF - 1;
      TM_RAS:  return RAS_EFF - 1;
      TM_RP:   return RP_EFF - 1;
      default: return RC_EFF - 1;
    endcase
  endfunction

  seq_st_t          st;
  cmd_t             cmd_q;
  logic             cke_q;
  logic [BA_W-1:0]  bank_q;
  logic [COL_W-1:0] col_q;
  logic             all_q;

  logic [TM_NUM-1:0] tm_ld;
  logic [TM_NUM-1:0] tm_done;

  logic accept, rd_go, pre_go;

  assign ready  = (st == ST_IDLE) && tm_done[TM_RC] && tm_done[TM_RP];
  assign accept = ready && req;
  assign rd_go  = (st == ST_WAIT_RD) && tm_done[TM_RCD];
  assign pre_go = (st == ST_WAIT_PRE) && tm_done[TM_RAS];

  // One down-counter per timing limit
  for (genvar g = 0; g < TM_NUM; g++) begin : g_tmr
    assign tm_ld[g] = (g == TM_RP) ? pre_go : accept;
    ddr_rd_tmr #(
      .W    (TW),
      .LOAD (load_of(g))
    ) u_tmr (
      .clk  (clk),
      .rst  (rst),
      .ld   (tm_ld[g]),
      .done (tm_done[g])
    );
  end

  // Sequencer and registered command bus
  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cmd_q  <= CMD_NOP;
      cke_q  <= 1'b1;
      addr   <= '0;
      ba     <= '0;
      bank_q <= '0;
      col_q  <= '0;
      all_q  <= 1'b0;
    end else begin
      cke_q <= 1'b1;
      cmd_q <= CMD_NOP;
      addr  <= '0;
      ba    <= '0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            cmd_q  <= CMD_ACT;
            addr   <= req_row;
            ba     <= req_bank;
            bank_q <= req_bank;
            col_q  <= req_col;
            all_q  <= req_all_pre;
            st     <= ST_WAIT_RD;
          end
        end
        ST_WAIT_RD: begin
          if (rd_go) begin
            cmd_q <= CMD_RD;
            addr  <= ROW_W'(col_q);
            ba    <= bank_q;
            st    <= ST_WAIT_PRE;
          end
        end
        ST_WAIT_PRE: begin
          if (pre_go) begin
            cmd_q        <= CMD_PRE;
            addr[AP_BIT] <= all_q;
            ba           <= bank_q;
            st           <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign cke = cke_q;

  ddr_rd_win #(
    .CAS_LAT (CAS_LAT),
    .BEATS   (BEATS)
  ) u_win (
    .clk   (clk),
    .rst   (rst),
    .rd_go (rd_go),
    .valid (rd_valid)
  );
endmodule

// File: rtl/ddr_rd_chk.sv
module ddr_rd_chk
  import ddr_rd_pkg::*;
#(
  parameter int ROW_W     = 12,
  parameter int BA_W      = 2,
  parameter int T_RCD_CYC = 3,
  parameter int T_RAS_CYC = 6,
  parameter int T_RP_CYC  = 3,
  parameter int T_RC_CYC  = 9,
  parameter int CAS_LAT   = 2,
  parameter int BURST_LEN = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             ready,
  input logic             cke,
  input logic             cs_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic [ROW_W-1:0] addr,
  input logic             rd_valid
);
  localparam int BEATS   = BURST_LEN / 2;
  localparam int RCD_EFF = imax(T_RCD_CYC, 2);
  localparam int RAS_EFF = imax(T_RAS_CYC, RCD_EFF + BEATS);
  localparam int RP_EFF  = imax(T_RP_CYC, 2);
  localparam int RC_EFF  = imax(T_RC_CYC, RAS_EFF + RP_EFF);
  localparam int SAT     = imax(RC_EFF, CAS_LAT + BEATS + 1);
  localparam int AW      = $clog2(SAT + 1);

  cmd_t c;
  assign c = {cs_n, ras_n, cas_n, we_n};

  logic [AW-1:0] act_age, pre_age, rd_age;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_age <= AW'(SAT);
      pre_age <= AW'(SAT);
      rd_age  <= AW'(SAT);
    end else begin
      act_age <= (c == CMD_ACT) ? AW'(1) : ((act_age < AW'(SAT)) ? act_age + 1'b1 : act_age);
      pre_age <= (c == CMD_PRE) ? AW'(1) : ((pre_age < AW'(SAT)) ? pre_age + 1'b1 : pre_age);
      rd_age  <= (c == CMD_RD)  ? AW'(1) : ((rd_age  < AW'(SAT)) ? rd_age  + 1'b1 : rd_age);
    end
  end

  a_r3_rcd_met: assert property (@(posedge clk) disable iff (rst)
    (c == CMD_RD) |-> (act_age >= AW'(RCD_EFF)));

  a_r3_no_autopre: assert property (@(posedge clk) disable iff (rst)
    (c == CMD_RD) |-> (addr[AP_BIT] == 1'b0));

  a_r4_ras_met: assert property (@(posedge clk) disable iff (rst)
    (c == CMD_PRE) |-> (act_age >= AW'(RAS_EFF)));

  a_r5_rc_met: assert property (@(posedge clk) disable iff (rst)
    (c == CMD_ACT) |-> (act_age >= AW'(RC_EFF)));

  a_r5_rp_met: assert property (@(posedge clk) disable iff (rst)
    (c == CMD_ACT) |-> (pre_age >= AW'(RP_EFF)));

  a_r6_ready_quiet: assert property (@(posedge clk) disable iff (rst)
    ready |-> (c == CMD_NOP));

  a_r7_valid_window: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_age >= AW'(CAS_LAT) && rd_age <= AW'(CAS_LAT + BEATS - 1)));

  a_r8_gap_after_cmd: assert property (@(posedge clk) disable iff (rst)
    (c != CMD_NOP) |=> (c == CMD_NOP));

  a_r8_legal_code: assert property (@(posedge clk) disable iff (rst)
    (c == CMD_NOP) || (c == CMD_ACT) || (c == CMD_RD) || (c == CMD_PRE));

  a_r9_cke_high: assert property (@(posedge clk) disable iff (rst) cke);
endmodule

bind ddr_rd_seq ddr_rd_chk #(
  .ROW_W     (ROW_W),
  .BA_W      (BA_W),
  .T_RCD_CYC (T_RCD_CYC),
  .T_RAS_CYC (T_RAS_CYC),
  .T_RP_CYC  (T_RP_CYC),
  .T_RC_CYC  (T_RC_CYC),
  .CAS_LAT   (CAS_LAT),
  .BURST_LEN (BURST_LEN)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ready    (ready),
  .cke      (cke),
  .cs_n     (cs_n),
  .ras_n    (ras_n),
  .cas_n    (cas_n),
  .we_n     (we_n),
  .addr     (addr),
  .rd_valid (rd_valid)
);

// File: tb/test_ddr_rd_seq.sv
module test_ddr_rd_seq;
  localparam int ROW_W = 12, COL_W = 8, BA_W = 2;
  localparam int TRCD = 3, TRAS = 6, TRP = 3, TRC = 9, CL = 2, BL = 4;

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_RCD = mx(TRCD, 2);
  localparam int E_RAS = mx(TRAS, E_RCD + BL / 2);
  localparam int E_RP  = mx(TRP, 2);
  localparam int E_RC  = mx(TRC, E_RAS + E_RP);

  localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RD = 4'b0101, PRE = 4'b0010;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic [BA_W-1:0]  req_bank = '0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic             req_all_pre = 1'b0;
  logic ready, cke, cs_n, ras_n, cas_n, we_n, rd_valid;
  logic [ROW_W-1:0] addr;
  logic [BA_W-1:0]  ba;

  always #10 clk = ~clk;

  ddr_rd_seq i_ddr_rd_seq (
    .clk(clk), .rst(rst), .req(req), .req_bank(req_bank), .req_row(req_row),
    .req_col(req_col), .req_all_pre(req_all_pre), .ready(ready), .cke(cke),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr),
    .ba(ba), .rd_valid(rd_valid)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  typedef struct {
    int bank;
    int row;
    int col;
    bit all;
    bit waited;
  } txn_t;

  txn_t q[$];
  txn_t cur;
  int last_act = -1000, last_pre = -1000, last_rd = -1000;
  bit busy = 1'b0, any_act = 1'b0, prev_cmd = 1'b0, mon_en = 1'b0;

  // Monitor: samples away from the active edge
  always @(negedge clk) begin
    if (mon_en) begin
      logic [3:0] c;
      bit exp_v, exp_r;
      c = {cs_n, ras_n, cas_n, we_n};
      chk(c == NOP || c == ACT || c == RD || c == PRE, "R8", "legal command code", int'(c), int'(NOP));
      chk(cke == 1'b1, "R9", "cke high", int'(cke), 1);
      if (c != NOP) chk(!prev_cmd, "R8", "NOP between commands", 1, 0);
      prev_cmd = (c != NOP);
      if (c == ACT) begin
        if (q.size() == 0) begin
          chk(1'b0, "R2", "ACTIVE without accepted request", 1, 0);
        end else begin
          cur = q.pop_front();
          chk(int'(ba) == cur.bank, "R2", "ACTIVE bank", int'(ba), cur.bank);
          chk(int'(addr) == cur.row, "R2", "ACTIVE row", int'(addr), cur.row);
          if (any_act) begin
            chk(cyc - last_act >= E_RC, "R5", "ACT to ACT gap", cyc - last_act, E_RC);
            chk(cyc - last_pre >= E_RP, "R5", "PRE to ACT gap", cyc - last_pre, E_RP);
            if (cur.waited)
              chk(cyc - last_act == E_RC, "R5", "waiting request ACT gap", cyc - last_act, E_RC);
          end
        end
        last_act = cyc;
        any_act  = 1'b1;
        busy     = 1'b1;
      end else if (c == RD) begin
        chk(busy, "R3", "READ inside access", int'(busy), 1);
        chk(cyc - last_act == E_RCD, "R3", "ACT to READ gap", cyc - last_act, E_RCD);
        chk(int'(addr) == cur.col, "R3", "READ address (A10 low)", int'(addr), cur.col);
        chk(int'(ba) == cur.bank, "R3", "READ bank", int'(ba), cur.bank);
        last_rd = cyc;
      end else if (c == PRE) begin
        chk(busy, "R4", "PRE inside access", int'(busy), 1);
        chk(cyc - last_act == E_RAS, "R4", "ACT to PRE gap", cyc - last_act, E_RAS);
        chk(addr[10] == cur.all, "R4", "PRE A10", int'(addr[10]), int'(cur.all));
        if (!cur.all) chk(int'(ba) == cur.bank, "R4", "PRE bank", int'(ba), cur.bank);
        busy     = 1'b0;
        last_pre = cyc;
      end
      exp_v = (cyc - last_rd == CL) || (cyc - last_rd == CL + 1);
      chk(rd_valid == exp_v, "R7", "rd_valid window", int'(rd_valid), int'(exp_v));
      exp_r = !busy && (cyc - last_act >= E_RC - 1) && (cyc - last_pre >= E_RP - 1);
      chk(ready == exp_r, "R6", "ready", int'(ready), int'(exp_r));
    end
  end

  // Present one request; returns at the negedge after it was taken
  task automatic send(input int b, input int r, input int cl, input bit a);
    txn_t t;
    t.bank = b; t.row = r; t.col = cl; t.all = a;
    req_bank = BA_W'(b);
    req_row  = ROW_W'(r);
    req_col  = COL_W'(cl);
    req_all_pre = a;
    req = 1'b1;
    t.waited = !ready;
    while (!ready) @(negedge clk);
    q.push_back(t);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    void'($urandom(32'h5EED_0D17));
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk(ready == 1'b1, "R1", "ready in reset", int'(ready), 1);
    chk({cs_n, ras_n, cas_n, we_n} == NOP, "R1", "NOP in reset", int'({cs_n, ras_n, cas_n, we_n}), int'(NOP));
    chk(cke == 1'b1, "R1", "cke in reset", int'(cke), 1);
    chk(rd_valid == 1'b0, "R1", "rd_valid in reset", int'(rd_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(ready == 1'b1, "R1", "ready after reset", int'(ready), 1);
    chk({cs_n, ras_n, cas_n, we_n} == NOP, "R1", "NOP after reset", int'({cs_n, ras_n, cas_n, we_n}), int'(NOP));
    mon_en = 1'b1;

    // Directed: back-to-back to the same bank, both precharge modes, column extremes
    send(0, 12'hABC, 8'h5A, 1'b0);
    send(0, 12'h123, 8'hFF, 1'b0);
    send(3, 12'hFFF, 8'h00, 1'b1);
    send(3, 12'h000, 8'h01, 1'b1);
    repeat (15) @(negedge clk);
    send(2, 12'h800, 8'h80, 1'b0);

    // Random traffic with random gaps
    for (int i = 0; i < 80; i++) begin
      int gap;
      gap = $urandom_range(0, 14);
      repeat (gap) @(negedge clk);
      send($urandom_range(0, 3), $urandom_range(0, 4095), $urandom_range(0, 255), 1'($urandom_range(0, 1)));
    end
    repeat (20) @(negedge clk);
    chk(q.size() == 0, "R2", "all accepted requests activated", q.size(), 0);
    mon_en = 1'b0;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog (all): actual=hung expected=finished");
    finish_run();
  end
endmodule